// File: doc/BRIEF.md
# Per-Band Over-Subtraction Unit

This block cleans one frequency band of a noisy magnitude spectrum. A band controller tells it which bins belong to the band, when a new frame starts and when the band's last bin has arrived. While bins stream through, two peak trackers hold the largest noisy-signal value and the largest noise-estimate value seen inside the band since the frame started. The signal-to-noise figure for the band is the ratio of these two peaks, kept in unsigned fixed point with 8 fractional bits.

On the band's last bin, this ratio is turned into an over-subtraction factor. The factor is large when the band is noisy and falls to one when the band is clean. It is then scaled by a weight chosen from where the band sits in frequency. The product is latched and used for the bins that follow. Every in-band bin leaves the block one cycle later as the noisy value minus the weighted noise estimate. A result below zero is forced to zero.

The dB breakpoints are compared as linear amplitude ratios, so the block needs no logarithm. The sloped middle part of the factor curve is a step table in Q4.8.

Top module: `band_oversub`

## Requirements
- R1: While rst_ni is low, and after it is released with no other activity, enh_o is 0, snr_o is 0 and factor_o is 0x100 (1.0 in Q4.8).
- R2: Each peak register holds the maximum of the values presented with band_en_i high since the last frame_start_i. A bin that has frame_start_i and band_en_i high together starts the peak at that bin's value. Bins with band_en_i low leave both peaks unchanged.
- R3: On a cycle with band_end_i high, snr_o loads floor(sig_peak·256 / noise_peak). The peaks used here include the bin presented in that same cycle. snr_o changes on no other cycle.
- R4: If the noise peak used at band end is zero, snr_o loads all ones and the over-subtraction factor is 1.0.
- R5: The over-subtraction factor α, in Q4.8, is chosen from the ratio r = snr_o value as follows:
  - r < 144 gives 1280 (5.0)
  - 144 ≤ r < 256 gives 1216 (4.75)
  - r < 455 gives 1024 (4.0)
  - r < 810 gives 832 (3.25)
  - r < 1440 gives 640 (2.5)
  - r < 2560 gives 448 (1.75)
  - r ≥ 2560 gives 256 (1.0)
- R6: The band weight comes from freq_class_i, in Q4.8:
  - code 0 (upper edge below 1 kHz) gives 256 (1.0)
  - code 1 (middle) gives 640 (2.5)
  - code 2 (within 2 kHz of Nyquist) gives 384 (1.5)
  - code 3 gives 256 (1.0)

  factor_o loads floor(α·weight/256) at band end.
- R7: One cycle after an in-band bin, enh_o equals sig − floor(noise·factor/256) when that difference is not negative, and 0 when it is.
- R8: enh_o holds its value on cycles that follow a bin with band_en_i low.
- R9: A bin presented in the band_end_i cycle is processed with the factor in effect before that cycle. The newly latched factor applies from the next bin onward, and factor_o changes only on band_end_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | First cycle of a frame; clears both peaks |
| band_en_i | input | 1 | Current bin lies inside this band |
| band_end_i | input | 1 | Last cycle of the band; latch SNR and factor |
| freq_class_i | input | 2 | Upper-edge frequency class of the band |
| sig_i | input | W | Noisy magnitude sample |
| noise_i | input | W | Noise estimate for the same bin |
| enh_o | output | W | Enhanced sample, registered |
| snr_o | output | W+8 | Latched peak ratio, 8 fractional bits |
| factor_o | output | 12 | Latched weighted over-subtraction factor, Q4.8 |

## Verification
Two pairs of events can land in one cycle. First, frame_start_i can arrive together with the first in-band bin, so the peak clear and the peak load happen at once. Second, band_end_i can arrive together with the last in-band bin, so the peak update, the factor latch and that bin's own subtraction all occur on the same edge. Every frame in the stimulus table is driven this way and includes a large out-of-band bin in its middle. The bench judges the results from the latched snr_o and factor_o values and from two enhanced samples. The sample of the band-end bin must still use the old factor. The sample that follows must use the new one.

// File: rtl/osb_pkg.sv
package osb_pkg;
  localparam int unsigned RATIO_FRAC = 8;
  localparam int unsigned GAIN_W     = 12;
  localparam int unsigned GAIN_FRAC  = 8;
  localparam int unsigned N_SEG      = 6;
  localparam int unsigned SEG_IDX_W  = $clog2(N_SEG + 1);

  typedef logic [GAIN_W-1:0] gain_t;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2,
    BAND_RSVD = 2'd3
  } fclass_e;

  localparam gain_t ONE_Q = gain_t'(1 << GAIN_FRAC);

  // ratio thresholds (Q8) for -5, 0, 5, 10, 15, 20 dB
  localparam int unsigned SEG_THR [N_SEG] = '{144, 256, 455, 810, 1440, 2560};

  // alpha per segment, Q4.8, stepped at each segment's lower edge
  localparam gain_t ALPHA_TAB [N_SEG+1] = '{
    12'd1280, 12'd1216, 12'd1024, 12'd832, 12'd640, 12'd448, 12'd256
  };

  function automatic gain_t band_weight(input fclass_e c);
    case (c)
      BAND_MID:  return 12'd640;
      BAND_HIGH: return 12'd384;
      default:   return ONE_Q;
    endcase
  endfunction
endpackage

// File: rtl/osb_peak.sv
module osb_peak #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] peak_o,
  output logic [W-1:0] peak_next_o
);
  logic [W-1:0] held_q;
  logic [W-1:0] base;

  always_comb begin
    base        = clr_i ? '0 : held_q;
    peak_next_o = (en_i && (d_i > base)) ? d_i : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= peak_next_o;
  end

  assign peak_o = held_q;

  assert_peak_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> (peak_o == $past(peak_o)));

  assert_peak_cover_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (peak_o >= $past(d_i)));
endmodule

// File: rtl/osb_ratio.sv
module osb_ratio #(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = 8,
  parameter int unsigned S    = W + FRAC
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [S-1:0] q_o
);
  logic [S-1:0] num_s;
  logic [S-1:0] den_s;

  always_comb begin
    num_s = {num_i, {FRAC{1'b0}}};
    den_s = S'(den_i);
    // zero noise peak: saturate to the top of the ratio range
    q_o   = (den_i == '0) ? '1 : (num_s / den_s);
  end
endmodule

// File: rtl/osb_factor_map.sv
module osb_factor_map
  import osb_pkg::*;
#(
  parameter int unsigned SNR_W = 24
) (
  input  logic [SNR_W-1:0] snr_i,
  input  logic [1:0]       fclass_i,
  output gain_t            gain_o
);
  localparam int unsigned PW = 2 * GAIN_W;

  logic [N_SEG-1:0]     above;
  logic [SEG_IDX_W-1:0] seg;
  gain_t                alpha;
  gain_t                weight;

  for (genvar k = 0; k < N_SEG; k++) begin : g_thr
    assign above[k] = (snr_i >= SNR_W'(SEG_THR[k]));
  end

  always_comb begin
    // thresholds rise monotonically, so the count of passed ones is the segment
    seg    = SEG_IDX_W'($countones(above));
    alpha  = ALPHA_TAB[seg];
    weight = band_weight(fclass_e'(fclass_i));
    gain_o = gain_t'((PW'(alpha) * PW'(weight)) >> GAIN_FRAC);
  end
endmodule

// File: rtl/osb_subtract.sv
module osb_subtract
  import osb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] sig_i,
  input  logic [W-1:0] noise_i,
  input  gain_t        gain_i,
  output logic [W-1:0] enh_o
);
  localparam int unsigned P = W + GAIN_W;

  logic [P-1:0] scaled;
  logic [P:0]   diff;
  logic [W-1:0] clamped;
  logic [W-1:0] enh_q;

  always_comb begin
    scaled  = (P'(noise_i) * P'(gain_i)) >> GAIN_FRAC;
    diff    = {1'b0, P'(sig_i)} - {1'b0, scaled};
    clamped = diff[P] ? '0 : W'(diff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   enh_q <= '0;
    else if (en_i) enh_q <= clamped;
  end

  assign enh_o = enh_q;

  assert_enh_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (enh_o <= $past(sig_i)));

  assert_enh_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(enh_o));
endmodule

// File: rtl/band_oversub.sv
module band_oversub
  import osb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_start_i,
  input  logic                    band_en_i,
  input  logic                    band_end_i,
  input  logic [1:0]              freq_class_i,
  input  logic [W-1:0]            sig_i,
  input  logic [W-1:0]            noise_i,
  output logic [W-1:0]            enh_o,
  output logic [W+RATIO_FRAC-1:0] snr_o,
  output logic [GAIN_W-1:0]       factor_o
);
  localparam int unsigned S     = W + RATIO_FRAC;
  localparam int unsigned N_TRK = 2;

  logic [W-1:0] trk_in   [N_TRK];
  logic [W-1:0] trk_pk   [N_TRK];
  logic [W-1:0] trk_next [N_TRK];
  logic [S-1:0] snr_next;
  gain_t        gain_next;
  logic [S-1:0] snr_q;
  gain_t        gain_q;

  assign trk_in[0] = sig_i;
  assign trk_in[1] = noise_i;

  for (genvar t = 0; t < N_TRK; t++) begin : g_trk
    osb_peak #(.W(W)) u_peak (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (frame_start_i),
      .en_i        (band_en_i),
      .d_i         (trk_in[t]),
      .peak_o      (trk_pk[t]),
      .peak_next_o (trk_next[t])
    );
  end

  osb_ratio #(.W(W), .FRAC(RATIO_FRAC), .S(S)) u_ratio (
    .num_i (trk_next[0]),
    .den_i (trk_next[1]),
    .q_o   (snr_next)
  );

  osb_factor_map #(.SNR_W(S)) u_map (
    .snr_i    (snr_next),
    .fclass_i (freq_class_i),
    .gain_o   (gain_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snr_q  <= '0;
      gain_q <= ONE_Q;
    end else if (band_end_i) begin
      snr_q  <= snr_next;
      gain_q <= gain_next;
    end
  end

  osb_subtract #(.W(W)) u_sub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (band_en_i),
    .sig_i   (sig_i),
    .noise_i (noise_i),
    .gain_i  (gain_q),
    .enh_o   (enh_o)
  );

  assign snr_o    = snr_q;
  assign factor_o = gain_q;

  assert_snr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !band_end_i |=> $stable(snr_o));

  assert_zero_noise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_end_i && (trk_next[1] == '0)) |=> (&snr_o));

  assert_low_band_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_end_i && (freq_class_i == BAND_LOW)) |=> (factor_o <= 12'd1280));

  assert_factor_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !band_end_i |=> $stable(factor_o));

  // unused-peak guard: held peaks must never exceed what the next-value path allows
  assert_peak_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |-> (trk_next[0] >= trk_pk[0]));
endmodule

// File: tb/band_oversub_tb.sv
module band_oversub_tb;
  import osb_pkg::*;

  localparam int W    = 16;
  localparam int S    = W + RATIO_FRAC;
  localparam int NVEC = 9;
  // s0 s1 s2 n0 n1 n2 class
  localparam int VEC [NVEC][7] = '{
    '{100, 300, 200, 50, 40, 60, 0},
    '{1000, 2000, 500, 10, 20, 15, 1},
    '{100, 50, 80, 200, 300, 100, 2},
    '{500, 400, 600, 300, 400, 350, 1},
    '{900, 100, 50, 0, 0, 0, 3},
    '{144, 10, 20, 256, 100, 5, 0},
    '{143, 10, 20, 256, 100, 5, 0},
    '{2560, 10, 20, 256, 100, 5, 0},
    '{2559, 10, 20, 256, 100, 5, 0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_ni = 1'b0;
  logic         frame_start = 1'b0, band_en = 1'b0, band_end = 1'b0;
  logic [1:0]   fclass = 2'd0;
  logic [W-1:0] sig = '0, noise = '0;
  logic [W-1:0] enh;
  logic [S-1:0] snr;
  logic [11:0]  factor;

  int     total = 0;
  int     bad = 0;
  longint cur_factor = 256;
  longint last_enh = 0;

  band_oversub #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start),
    .band_en_i(band_en), .band_end_i(band_end), .freq_class_i(fclass),
    .sig_i(sig), .noise_i(noise), .enh_o(enh), .snr_o(snr), .factor_o(factor)
  );

  function automatic longint exp_alpha(longint r);
    if (r < 144)  return 1280;
    if (r < 256)  return 1216;
    if (r < 455)  return 1024;
    if (r < 810)  return 832;
    if (r < 1440) return 640;
    if (r < 2560) return 448;
    return 256;
  endfunction

  function automatic longint exp_weight(int c);
    if (c == 1) return 640;
    if (c == 2) return 384;
    return 256;
  endfunction

  function automatic longint exp_snr(longint sp, longint np);
    if (np == 0) return (longint'(1) << S) - 1;
    return (sp * 256) / np;
  endfunction

  function automatic longint exp_enh(longint s, longint n, longint f);
    longint p;
    p = (n * f) / 256;
    return (s > p) ? s - p : 0;
  endfunction

  task automatic chk(string req, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(bit fs, bit en, bit be, int c, int s, int n);
    @(negedge clk);
    frame_start = fs; band_en = en; band_end = be;
    fclass = 2'(c); sig = W'(s); noise = W'(n);
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    frame_start = 0; band_en = 0; band_end = 0; sig = '0; noise = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #2;
    cur_factor = 256;
    last_enh = 0;
  endtask

  task automatic run_frame(int v);
    int     c;
    longint sp, np, ef, e;
    c  = VEC[v][6];
    sp = VEC[v][0];
    np = VEC[v][3];
    for (int k = 1; k < 3; k++) begin
      if (VEC[v][k] > sp) sp = VEC[v][k];
      if (VEC[v][3+k] > np) np = VEC[v][3+k];
    end
    // first bin together with frame start
    step(1, 1, 0, c, VEC[v][0], VEC[v][3]);
    e = exp_enh(VEC[v][0], VEC[v][3], cur_factor);
    chk($sformatf("R7 vec%0d bin0 enh", v), enh, e);
    // large out-of-band bin: must not touch peaks or enh
    step(0, 0, 0, c, 60000, 60000);
    chk($sformatf("R8 vec%0d oob enh", v), enh, e);
    step(0, 1, 0, c, VEC[v][1], VEC[v][4]);
    chk($sformatf("R7 vec%0d bin1 enh", v), enh, exp_enh(VEC[v][1], VEC[v][4], cur_factor));
    // last bin together with band end: still uses the old factor
    step(0, 1, 1, c, VEC[v][2], VEC[v][5]);
    chk($sformatf("R9 vec%0d last bin old factor", v), enh, exp_enh(VEC[v][2], VEC[v][5], cur_factor));
    chk($sformatf("R3 R4 vec%0d snr", v), snr, exp_snr(sp, np));
    ef = (exp_alpha(exp_snr(sp, np)) * exp_weight(c)) / 256;
    chk($sformatf("R5 R6 vec%0d factor", v), factor, ef);
    cur_factor = ef;
    step(0, 1, 0, c, 1000, 100);
    chk($sformatf("R9 vec%0d new factor applied", v), enh, exp_enh(1000, 100, cur_factor));
    step(0, 1, 0, c, 10, 100);
    chk($sformatf("R7 vec%0d clamp", v), enh, exp_enh(10, 100, cur_factor));
    last_enh = exp_enh(10, 100, cur_factor);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    do_reset();
    chk("R1 reset enh", enh, 0);
    chk("R1 reset snr", snr, 0);
    chk("R1 reset factor", factor, 256);
    idle();
    chk("R3 no band end keeps snr", snr, 0);

    for (int v = 0; v < NVEC; v++) run_frame(v);

    // R8: changing inputs with band_en low leave enh unchanged
    step(0, 0, 0, 1, 4000, 0);
    chk("R8 hold after oob", enh, last_enh);
    step(0, 0, 0, 2, 7, 9);
    chk("R8 hold second oob", enh, last_enh);

    // R4 corner: frame with no in-band bins, band end on an out-of-band cycle
    step(1, 0, 0, 1, 500, 500);
    step(0, 0, 1, 1, 800, 900);
    chk("R4 empty band snr saturates", snr, (longint'(1) << S) - 1);
    chk("R4 R6 empty band factor", factor, 640);
    cur_factor = 640;

    // R2: frame start with a small bin discards the earlier larger peak
    step(0, 1, 0, 0, 5000, 10);
    step(1, 1, 0, 0, 300, 100);
    step(0, 1, 1, 0, 200, 50);
    chk("R2 peak restarted at frame start", snr, 768);
    chk("R5 factor for ratio 768", factor, 832);

    // R1 again after a mid-run reset
    do_reset();
    chk("R1 re-reset enh", enh, 0);
    chk("R1 re-reset snr", snr, 0);
    chk("R1 re-reset factor", factor, 256);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule